// File: doc/BRIEF.md
# Control and Status Register Access Unit

This block carries out the six register-access instructions of the control-and-status extension against a small set of registers that it holds itself. Each request presents the three-bit operation code, the destination and source register indices, the 12-bit register address, the source operand value and the current privilege level. In a single step the unit decides whether the access reads the addressed register, writes it, or does both. It computes the replacement value for plain write, bit-set and bit-clear forms, returns the previous contents for the destination register, and reports a fault when the access is not allowed. One clock edge after a request, a registered response holds the destination write enable, the data, a fault flag and a pipeline-flush request.

Reading and writing are decided only from the instruction form and from whether the destination index or the source field is zero. Whether the new value differs from the old value plays no part. This keeps both read and write side effects under the control of the program. A read-activity counter, readable at address 0xCC0, makes read side effects visible at the ports: every read that is carried out increments it.

Top module: `csr_access_unit`

## Requirements
- R1: Operation codes 001, 010 and 011 store the operand, old OR operand, and old AND NOT operand respectively. When a read is performed, the response carries the old value zero-extended, with the destination write enable high.
- R2: For codes 001 and 101 with destination index 0, no read happens: the destination write enable stays low and the read-activity counter (0xCC0) does not advance.
- R3: For codes 010, 011, 110 and 111 with source field 0, no write happens. There is no store, no read-only fault and no flush, even when the operand value is non-zero.
- R4: The write decision depends only on the form and the fields. Storing a value equal to the old one still counts as a write and still raises the side effects of a write.
- R5: The access faults when the privilege input (0 user, 1 supervisor, 3 machine) is numerically below address bits [9:8].
- R6: An access that would write an address whose bits [11:10] are 2'b11 faults.
- R7: The access faults for an address outside the implemented set {0x001 flags, 0x002 rounding mode, 0x003 combined float control, 0x180 translation base, 0x340 scratch, 0xCC0 read-activity counter}, and for operation codes 000 and 100.
- R8: A faulting access changes no register, leaves the destination write enable low, and does not flush. It also does not advance the read-activity counter.
- R9: Address 0x003 reads as the 5 flag bits in [4:0] OR the 3-bit rounding mode shifted left by 5. A write to it puts bits [4:0] into the flags and bits [7:5] into the rounding mode.
- R10: A stored value is ANDed with the register's writable mask: 0x1F for the flags, 0x7 for the rounding mode, 0xFF for the combined register, and all ones for the translation base and the scratch register.
- R11: A write that is carried out at address 0x180 raises the flush output in the response.
- R12: Codes 101, 110 and 111 use the 5-bit source index field, zero-extended, as the operand and ignore the operand value input.
- R13: The response appears exactly one cycle after the request. Synchronous reset clears all registers and all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_funct3 | input | 3 | Access operation code |
| req_rd | input | REG_IDX_W | Destination register index |
| req_rs1 | input | REG_IDX_W | Source register index or immediate |
| req_addr | input | 12 | Register address |
| req_rs1_val | input | XLEN | Source operand value |
| req_priv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response present |
| rsp_rd | output | REG_IDX_W | Destination index echoed |
| rsp_rd_we | output | 1 | Destination write enable |
| rsp_rd_data | output | XLEN | Old register value for destination |
| rsp_illegal | output | 1 | Access faulted |
| rsp_flush | output | 1 | Squash younger instructions |

## Verification
If a register held a wrong value, the fault would reach the ports only on the next read of that address, which comes one cycle after that request. The vector sequence therefore reads back every register after it is modified. If the read or write decision were wrong, the symptom would show in the same response as a missing write enable or a missing flush. It would also show later as a changed read-activity count, and the counter is sampled after each run of reads that were suppressed or that faulted. If masking or splitting of the combined float register were wrong, the fault would appear on the next read through the other alias.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam logic [11:0] ADR_FLAGS   = 12'h001;
  localparam logic [11:0] ADR_RMODE   = 12'h002;
  localparam logic [11:0] ADR_FCTRL   = 12'h003;
  localparam logic [11:0] ADR_XLATE   = 12'h180;
  localparam logic [11:0] ADR_SCRATCH = 12'h340;
  localparam logic [11:0] ADR_RDCNT   = 12'hCC0;

  localparam int FLG_W    = 5;
  localparam int RM_W     = 3;
  localparam int RM_SHIFT = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic    f3_ok;
    logic    use_imm;
    logic    rd_en;
    logic    wr_en;
    csr_op_e op;
  } csr_ctl_t;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [2:0]           funct3,
  input  logic [REG_IDX_W-1:0] rd_idx,
  input  logic [REG_IDX_W-1:0] rs1_idx,
  output csr_ctl_t             ctl
);
  always_comb begin
    ctl         = '0;
    ctl.use_imm = funct3[2];
    case (funct3[1:0])
      2'b01: begin
        ctl.f3_ok = 1'b1;
        ctl.op    = OP_WRITE;
        ctl.wr_en = 1'b1;
        ctl.rd_en = (rd_idx != '0);
      end
      2'b10: begin
        ctl.f3_ok = 1'b1;
        ctl.op    = OP_SET;
        ctl.rd_en = 1'b1;
        ctl.wr_en = (rs1_idx != '0);
      end
      2'b11: begin
        ctl.f3_ok = 1'b1;
        ctl.op    = OP_CLEAR;
        ctl.rd_en = 1'b1;
        ctl.wr_en = (rs1_idx != '0);
      end
      default: begin
        ctl.f3_ok = 1'b0;
        ctl.op    = OP_NONE;
      end
    endcase
  end
endmodule

// File: rtl/csr_alu.sv
module csr_alu
  import csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] wmask,
  output logic [XLEN-1:0] new_val
);
  logic [XLEN-1:0] raw;

  always_comb begin
    case (op)
      OP_WRITE: raw = src;
      OP_SET:   raw = old_val | src;
      OP_CLEAR: raw = old_val & ~src;
      default:  raw = old_val;
    endcase
    new_val = raw & wmask;
  end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [11:0]     addr,
  input  logic            rd_fire,
  input  logic            wr_fire,
  input  logic [XLEN-1:0] wdata,
  output logic            hit,
  output logic [XLEN-1:0] old_val,
  output logic [XLEN-1:0] wmask
);
  localparam int N_CSR     = 6;
  localparam int I_FLAGS   = 0;
  localparam int I_RMODE   = 1;
  localparam int I_FCTRL   = 2;
  localparam int I_XLATE   = 3;
  localparam int I_SCRATCH = 4;
  localparam int I_RDCNT   = 5;
  localparam logic [11:0] ADR_TAB [N_CSR] = '{
    ADR_FLAGS, ADR_RMODE, ADR_FCTRL, ADR_XLATE, ADR_SCRATCH, ADR_RDCNT
  };

  logic [N_CSR-1:0] sel;
  logic [FLG_W-1:0] flags_q;
  logic [RM_W-1:0]  rmode_q;
  logic [XLEN-1:0]  xlate_q;
  logic [XLEN-1:0]  scratch_q;
  logic [CNT_W-1:0] rdcnt_q;

  for (genvar g = 0; g < N_CSR; g++) begin : g_sel
    assign sel[g] = (addr == ADR_TAB[g]);
  end
  assign hit = |sel;

  always_comb begin
    old_val = '0;
    wmask   = '0;
    if (sel[I_FLAGS]) begin
      old_val = XLEN'(flags_q);
      wmask   = XLEN'({FLG_W{1'b1}});
    end
    if (sel[I_RMODE]) begin
      old_val = XLEN'(rmode_q);
      wmask   = XLEN'({RM_W{1'b1}});
    end
    if (sel[I_FCTRL]) begin
      old_val = XLEN'({rmode_q, flags_q});
      wmask   = XLEN'({(RM_W + FLG_W){1'b1}});
    end
    if (sel[I_XLATE]) begin
      old_val = xlate_q;
      wmask   = '1;
    end
    if (sel[I_SCRATCH]) begin
      old_val = scratch_q;
      wmask   = '1;
    end
    if (sel[I_RDCNT]) begin
      old_val = XLEN'(rdcnt_q);
      wmask   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      rmode_q   <= '0;
      xlate_q   <= '0;
      scratch_q <= '0;
      rdcnt_q   <= '0;
    end else begin
      if (rd_fire) rdcnt_q <= rdcnt_q + 1'b1;
      if (wr_fire) begin
        if (sel[I_FLAGS]) flags_q <= wdata[FLG_W-1:0];
        if (sel[I_RMODE]) rmode_q <= wdata[RM_W-1:0];
        if (sel[I_FCTRL]) begin
          flags_q <= wdata[FLG_W-1:0];
          rmode_q <= wdata[RM_SHIFT +: RM_W];
        end
        if (sel[I_XLATE])   xlate_q   <= wdata;
        if (sel[I_SCRATCH]) scratch_q <= wdata;
      end
    end
  end

  // R2
  rdcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rdcnt_q));
  // R8
  scratch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && sel[I_SCRATCH]) |=> $stable(scratch_q));
  // R10
  flags_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> ($stable(flags_q) && $stable(rmode_q) && $stable(xlate_q)));
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [2:0]           req_funct3,
  input  logic [REG_IDX_W-1:0] req_rd,
  input  logic [REG_IDX_W-1:0] req_rs1,
  input  logic [11:0]          req_addr,
  input  logic [XLEN-1:0]      req_rs1_val,
  input  logic [1:0]           req_priv,
  output logic                 rsp_valid,
  output logic [REG_IDX_W-1:0] rsp_rd,
  output logic                 rsp_rd_we,
  output logic [XLEN-1:0]      rsp_rd_data,
  output logic                 rsp_illegal,
  output logic                 rsp_flush
);
  csr_ctl_t        ctl;
  logic            hit;
  logic [XLEN-1:0] old_val, wmask, new_val, src;
  logic            priv_low, ro_write, illegal, fire, rd_fire, wr_fire;

  csr_decode #(.REG_IDX_W(REG_IDX_W)) u_dec (
    .funct3  (req_funct3),
    .rd_idx  (req_rd),
    .rs1_idx (req_rs1),
    .ctl     (ctl)
  );

  assign src = ctl.use_imm ? XLEN'(req_rs1) : req_rs1_val;

  csr_alu #(.XLEN(XLEN)) u_alu (
    .op      (ctl.op),
    .old_val (old_val),
    .src     (src),
    .wmask   (wmask),
    .new_val (new_val)
  );

  assign priv_low = (req_priv < req_addr[9:8]);
  assign ro_write = ctl.wr_en && (req_addr[11:10] == 2'b11);
  assign illegal  = !ctl.f3_ok || !hit || priv_low || ro_write;
  assign fire     = req_valid && !illegal;
  assign rd_fire  = fire && ctl.rd_en;
  assign wr_fire  = fire && ctl.wr_en;

  csr_regfile #(.XLEN(XLEN), .CNT_W(CNT_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .addr    (req_addr),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire),
    .wdata   (new_val),
    .hit     (hit),
    .old_val (old_val),
    .wmask   (wmask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rd      <= '0;
      rsp_rd_we   <= 1'b0;
      rsp_rd_data <= '0;
      rsp_illegal <= 1'b0;
      rsp_flush   <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rd      <= req_rd;
      rsp_rd_we   <= rd_fire;
      rsp_rd_data <= rd_fire ? old_val : '0;
      rsp_illegal <= req_valid && illegal;
      rsp_flush   <= wr_fire && (req_addr == ADR_XLATE);
    end
  end

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (!rsp_rd_we && !rsp_flush));
  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  no_read_x0_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_funct3[1:0] == 2'b01 && req_rd == '0) |=> !rsp_rd_we);
  // R3
  no_write_zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_funct3[1] && req_rs1 == '0) |=> !rsp_flush);
  // R5
  priv_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv < req_addr[9:8]) |=> rsp_illegal);
endmodule

// File: tb/test_csr_access_unit.sv
`timescale 1ns/100ps
module test_csr_access_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_funct3;
  logic [4:0]  req_rd, req_rs1;
  logic [11:0] req_addr;
  logic [31:0] req_rs1_val;
  logic [1:0]  req_priv;
  logic        rsp_valid, rsp_rd_we, rsp_illegal, rsp_flush;
  logic [4:0]  rsp_rd;
  logic [31:0] rsp_rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  csr_access_unit i_csr_access_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_funct3(req_funct3),
    .req_rd(req_rd), .req_rs1(req_rs1), .req_addr(req_addr),
    .req_rs1_val(req_rs1_val), .req_priv(req_priv), .rsp_valid(rsp_valid),
    .rsp_rd(rsp_rd), .rsp_rd_we(rsp_rd_we), .rsp_rd_data(rsp_rd_data),
    .rsp_illegal(rsp_illegal), .rsp_flush(rsp_flush)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  f3;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [11:0] addr;
    logic [31:0] val;
    logic [1:0]  priv;
    logic        ill;
    logic        we;
    logic [31:0] data;
    logic        fl;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  3'b001, 5'd5,  5'd1,  12'h340, 32'hA5A50001, 2'd3, 1'b0, 1'b1, 32'h00000000, 1'b0}, // R1
    '{4'd1,  3'b010, 5'd6,  5'd2,  12'h340, 32'h000000F0, 2'd3, 1'b0, 1'b1, 32'hA5A50001, 1'b0}, // R1
    '{4'd1,  3'b011, 5'd7,  5'd3,  12'h340, 32'hA5A50000, 2'd3, 1'b0, 1'b1, 32'hA5A500F1, 1'b0}, // R1
    '{4'd3,  3'b010, 5'd8,  5'd0,  12'h340, 32'hFFFFFFFF, 2'd3, 1'b0, 1'b1, 32'h000000F1, 1'b0}, // R3
    '{4'd12, 3'b101, 5'd9,  5'd31, 12'h001, 32'hDEADBEEF, 2'd3, 1'b0, 1'b1, 32'h00000000, 1'b0}, // R12
    '{4'd12, 3'b110, 5'd10, 5'd6,  12'h002, 32'hFFFFFFFF, 2'd3, 1'b0, 1'b1, 32'h00000000, 1'b0}, // R12
    '{4'd9,  3'b010, 5'd11, 5'd0,  12'h003, 32'h00000000, 2'd3, 1'b0, 1'b1, 32'h000000DF, 1'b0}, // R9
    '{4'd10, 3'b001, 5'd12, 5'd4,  12'h003, 32'hFFFFFF2A, 2'd3, 1'b0, 1'b1, 32'h000000DF, 1'b0}, // R10
    '{4'd12, 3'b111, 5'd13, 5'd2,  12'h001, 32'h00000000, 2'd3, 1'b0, 1'b1, 32'h0000000A, 1'b0}, // R12
    '{4'd9,  3'b010, 5'd14, 5'd0,  12'h003, 32'h00000000, 2'd3, 1'b0, 1'b1, 32'h00000028, 1'b0}, // R9
    '{4'd11, 3'b001, 5'd0,  5'd5,  12'h180, 32'h80001234, 2'd1, 1'b0, 1'b0, 32'h00000000, 1'b1}, // R11
    '{4'd5,  3'b010, 5'd15, 5'd0,  12'h180, 32'h00000000, 2'd1, 1'b0, 1'b1, 32'h80001234, 1'b0}, // R5
    '{4'd5,  3'b010, 5'd16, 5'd0,  12'h180, 32'h00000000, 2'd0, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R5
    '{4'd5,  3'b001, 5'd17, 5'd6,  12'h340, 32'h00000000, 2'd1, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R5
    '{4'd2,  3'b010, 5'd18, 5'd0,  12'hCC0, 32'h00000000, 2'd0, 1'b0, 1'b1, 32'h0000000B, 1'b0}, // R2
    '{4'd6,  3'b010, 5'd19, 5'd1,  12'hCC0, 32'h00000001, 2'd3, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R6
    '{4'd6,  3'b101, 5'd20, 5'd0,  12'hCC0, 32'h00000000, 2'd3, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R6
    '{4'd7,  3'b010, 5'd21, 5'd0,  12'h7C0, 32'h00000000, 2'd3, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R7
    '{4'd2,  3'b001, 5'd0,  5'd7,  12'h340, 32'h000000F1, 2'd3, 1'b0, 1'b0, 32'h00000000, 1'b0}, // R2
    '{4'd3,  3'b011, 5'd22, 5'd0,  12'h180, 32'hFFFFFFFF, 2'd3, 1'b0, 1'b1, 32'h80001234, 1'b0}, // R3
    '{4'd2,  3'b010, 5'd23, 5'd0,  12'hCC0, 32'h00000000, 2'd3, 1'b0, 1'b1, 32'h0000000D, 1'b0}, // R2
    '{4'd7,  3'b000, 5'd24, 5'd1,  12'h340, 32'h00000000, 2'd3, 1'b1, 1'b0, 32'h00000000, 1'b0}, // R7
    '{4'd4,  3'b010, 5'd1,  5'd9,  12'h180, 32'h00000000, 2'd3, 1'b0, 1'b1, 32'h80001234, 1'b1}, // R4
    '{4'd8,  3'b110, 5'd2,  5'd0,  12'hCC0, 32'h00000000, 2'd3, 1'b0, 1'b1, 32'h0000000F, 1'b0}, // R8
    '{4'd8,  3'b010, 5'd3,  5'd0,  12'h340, 32'h00000000, 2'd3, 1'b0, 1'b1, 32'h000000F1, 1'b0}  // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] f3, input logic [4:0] rd, input logic [4:0] rs1,
                       input logic [11:0] addr, input logic [31:0] val, input logic [1:0] priv);
    @(negedge clk);
    req_valid = 1'b1; req_funct3 = f3; req_rd = rd; req_rs1 = rs1;
    req_addr = addr; req_rs1_val = val; req_priv = priv;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R13 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_funct3 = '0; req_rd = '0; req_rs1 = '0;
    req_addr = '0; req_rs1_val = '0; req_priv = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state of the response
    check("R13 rst valid", 32'(rsp_valid), 32'd0);
    check("R13 rst we", 32'(rsp_rd_we), 32'd0);
    check("R13 rst illegal", 32'(rsp_illegal), 32'd0);
    check("R13 rst flush", 32'(rsp_flush), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[i].req, i);
      issue(VEC[i].f3, VEC[i].rd, VEC[i].rs1, VEC[i].addr, VEC[i].val, VEC[i].priv);
      check({t, " valid"}, 32'(rsp_valid), 32'd1);
      check({t, " illegal"}, 32'(rsp_illegal), 32'(VEC[i].ill));
      check({t, " we"}, 32'(rsp_rd_we), 32'(VEC[i].we));
      if (VEC[i].we) check({t, " data"}, rsp_rd_data, VEC[i].data);
      check({t, " flush"}, 32'(rsp_flush), 32'(VEC[i].fl));
      check({t, " rd"}, 32'(rsp_rd), 32'(VEC[i].rd));
    end

    // R13 idle cycle after request gives no response
    @(negedge clk);
    check("R13 idle valid", 32'(rsp_valid), 32'd0);

    // R13 mid-run reset clears registers and the counter
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    issue(3'b010, 5'd4, 5'd0, 12'h340, 32'h0, 2'd3);
    check("R13 scratch after reset", rsp_rd_data, 32'h0);
    issue(3'b010, 5'd4, 5'd0, 12'hCC0, 32'h0, 2'd3);
    check("R13 counter after reset", rsp_rd_data, 32'h1);
    issue(3'b010, 5'd4, 5'd0, 12'h003, 32'h0, 2'd3);
    check("R9 fctrl after reset", rsp_rd_data, 32'h0);

    finish_run();
  end
endmodule